// File: doc/BRIEF.md
# Start-Stop Serial Frame Transmitter

This block turns parallel characters into asynchronous start-stop frames on a single output line. A character is offered on a valid/ready pair together with a flag that marks it as an address. Once accepted, it is sent as one low start bit, then 5 to 8 data bits, then an optional extra bit, then a high stop period.

The extra bit is either a parity bit or, in multidrop networks, an address/data marker. The stop period is one or two whole bits, or a length set in sixteenths of a bit.

Bit timing comes from a single enable input, `tick`. In the asynchronous mode one bit spans sixteen ticks. In the isochronous mode each tick marks one whole bit, with no oversampling. The block latches its configuration when it accepts a character. When characters arrive without a pause, frames follow each other with no idle time between them.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `txd` carries the start bit, which is 0. In asynchronous mode every non-stop bit lasts 16 `tick` pulses.
- R3: Data bits follow the start bit, least significant bit first. The count is 5 + `cfg_len` (`cfg_len` 0..3 gives 5..8 bits), and unused upper bits of `in_data` are ignored.
- R4: With `cfg_par_en`=1 and `cfg_multidrop`=0, one bit follows the data, selected by `cfg_par_mode`: 0 makes the count of ones in data plus parity even, 1 makes it odd, 2 sends a constant 0, 3 sends a constant 1.
- R5: With `cfg_multidrop`=1, the bit after the data is `in_addr` (1 address, 0 data). It replaces any parity bit, whatever `cfg_par_en` holds.
- R6: In asynchronous mode with `cfg_frac_en`=0, the stop period is high for 16 ticks when `cfg_stop2`=0 and 32 ticks when `cfg_stop2`=1.
- R7: In asynchronous mode with `cfg_frac_en`=1, the stop period lasts 16 + `cfg_stop_frac` ticks, from 1 to 31/16 bits. `cfg_stop2` is then ignored.
- R8: With `cfg_iso`=1, every bit (start, data, extra) lasts one tick and the stop period lasts 1 or 2 ticks according to `cfg_stop2`. `cfg_stop_frac` and `cfg_frac_en` are ignored.
- R9: `in_ready` is also 1 during a cycle where `tick` completes the final tick of the stop period. A character accepted there starts its start bit in the next cycle, with no idle gap.
- R10: `txd` changes only in the cycle after a clock edge with `tick`=1 or after an accepting edge.
- R11: The configuration is sampled at the accepting edge. Changes made while a frame is in progress do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-timing enable: 16 per bit in asynchronous mode, 1 per bit in isochronous mode |
| cfg_len | input | 2 | Data length select, 5 + value bits |
| cfg_par_en | input | 1 | Append parity bit |
| cfg_par_mode | input | 2 | 0 even, 1 odd, 2 forced 0, 3 forced 1 |
| cfg_stop2 | input | 1 | Two whole stop bits |
| cfg_frac_en | input | 1 | Use fractional stop length (asynchronous only) |
| cfg_stop_frac | input | 4 | Extra stop length in sixteenths of a bit |
| cfg_multidrop | input | 1 | Send address/data marker bit after data |
| cfg_iso | input | 1 | Isochronous mode, one tick per bit |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be accepted this cycle |
| in_data | input | 8 | Character bits |
| in_addr | input | 1 | Character is an address (multidrop) |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: 8 data bits at most and 16 ticks per bit. These values reach all four character lengths. They also make every sixteenth of a stop bit exactly one tick, so each fractional stop length from 16 to 31 ticks can be observed, along with the 32-tick two-bit stop.

Tick density, character spacing and configuration are varied in blocks, with valid held high in some of them, so that back-to-back frames meet the ready signal on the final stop tick. A final block changes configuration in the middle of frames, which tests that the frame in flight keeps the settings latched when it was accepted.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_MAX = 8,
  parameter int OVS      = 16,
  parameter int FRAC_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic [1:0]          cfg_par_mode,
  input  logic                cfg_stop2,
  input  logic                cfg_frac_en,
  input  logic [FRAC_W-1:0]   cfg_stop_frac,
  input  logic                cfg_multidrop,
  input  logic                cfg_iso,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic                in_addr,
  output logic                txd,
  output logic                busy
);
  localparam int FRAME_W = DATA_MAX + 2;
  localparam int TCNT_W  = $clog2(2 * OVS + 1);
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_STOP} st_t;

  st_t                st;
  logic [FRAME_W-1:0] sh;
  logic [BCNT_W-1:0]  bcnt;
  logic [TCNT_W-1:0]  tcnt, bit_len_q, stop_len_q;

  logic [BCNT_W-1:0]  n_data;
  logic               has_x, x_bit, par_bit;
  logic [FRAME_W-1:0] frame;
  logic [TCNT_W-1:0]  bit_len_n, stop_len_n;
  logic [DATA_MAX-1:0] dmask;

  wire [TCNT_W-1:0] cur_len = (st == S_STOP) ? stop_len_q : bit_len_q;
  wire seg_end = tick && (tcnt == cur_len - TCNT_W'(1));
  wire accept  = in_valid && in_ready;

  assign in_ready = (st == S_IDLE) || (st == S_STOP && seg_end);
  assign busy     = (st != S_IDLE);
  assign txd      = (st == S_BITS) ? sh[0] : 1'b1;

  assign n_data = BCNT_W'(cfg_len) + BCNT_W'(5);
  assign has_x  = cfg_multidrop || cfg_par_en;
  assign x_bit  = cfg_multidrop ? in_addr : par_bit;

  always_comb begin
    for (int i = 0; i < DATA_MAX; i++)
      dmask[i] = (BCNT_W'(i) < n_data) ? in_data[i] : 1'b0;
    case (cfg_par_mode)
      2'd0:    par_bit = ^dmask;
      2'd1:    par_bit = ~^dmask;
      2'd2:    par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
  end

  always_comb begin
    frame = '0;
    for (int i = 0; i < DATA_MAX; i++)
      frame[i+1] = dmask[i];
    for (int j = 1; j <= DATA_MAX; j++)
      if (has_x && BCNT_W'(j) == n_data) frame[j+1] = x_bit;
  end

  always_comb begin
    bit_len_n = cfg_iso ? TCNT_W'(1) : TCNT_W'(OVS);
    if (cfg_iso)
      stop_len_n = cfg_stop2 ? TCNT_W'(2) : TCNT_W'(1);
    else if (cfg_frac_en)
      stop_len_n = TCNT_W'(OVS) + TCNT_W'(cfg_stop_frac);
    else
      stop_len_n = cfg_stop2 ? TCNT_W'(2 * OVS) : TCNT_W'(OVS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sh         <= '1;
      bcnt       <= '0;
      tcnt       <= '0;
      bit_len_q  <= TCNT_W'(OVS);
      stop_len_q <= TCNT_W'(OVS);
    end else if (accept) begin
      st         <= S_BITS;
      sh         <= frame;
      bcnt       <= n_data + BCNT_W'(has_x);
      tcnt       <= '0;
      bit_len_q  <= bit_len_n;
      stop_len_q <= stop_len_n;
    end else if (tick) begin
      case (st)
        S_BITS: begin
          if (seg_end) begin
            tcnt <= '0;
            if (bcnt == '0) st <= S_STOP;
            else begin
              sh   <= {1'b1, sh[FRAME_W-1:1]};
              bcnt <= bcnt - BCNT_W'(1);
            end
          end else tcnt <= tcnt + TCNT_W'(1);
        end
        S_STOP: begin
          if (seg_end) begin
            tcnt <= '0;
            st   <= S_IDLE;
          end else tcnt <= tcnt + TCNT_W'(1);
        end
        default: tcnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !txd));
  assert_frame_ends_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));
  assert_line_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick || (in_valid && in_ready)));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .busy(busy)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] cfg_len = 3, cfg_par_mode = 0;
  logic cfg_par_en = 0, cfg_stop2 = 0, cfg_frac_en = 0, cfg_multidrop = 0, cfg_iso = 0;
  logic [3:0] cfg_stop_frac = 0;
  logic in_valid = 0, in_addr = 0;
  logic [7:0] in_data = 0;
  logic in_ready, txd, busy;

  int nchk = 0, nerr = 0;
  int q_lv[$], q_dur[$];
  string q_tag[$];
  string ctx = "";

  always #10 clk = ~clk;

  uart_frame_tx dut (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, ctx, act, exp, $time);
    end
  endtask

  function automatic bit m_ready();
    return q_lv.size() == 0 || (q_lv.size() == 1 && q_dur[0] == 1 && tick);
  endfunction

  task automatic build();
    int n, ones, bl, xb;
    q_lv.delete(); q_dur.delete(); q_tag.delete();
    n = 5 + cfg_len;
    bl = cfg_iso ? 1 : 16;
    q_lv.push_back(0); q_dur.push_back(bl); q_tag.push_back("R2");
    ones = 0;
    for (int i = 0; i < n; i++) begin
      q_lv.push_back(in_data[i]); q_dur.push_back(bl); q_tag.push_back("R3");
      ones += in_data[i];
    end
    if (cfg_multidrop) begin
      q_lv.push_back(in_addr); q_dur.push_back(bl); q_tag.push_back("R5");
    end else if (cfg_par_en) begin
      case (cfg_par_mode)
        0: xb = ones % 2;
        1: xb = 1 - ones % 2;
        2: xb = 0;
        default: xb = 1;
      endcase
      q_lv.push_back(xb); q_dur.push_back(bl); q_tag.push_back("R4");
    end
    q_lv.push_back(1);
    if (cfg_iso) begin q_dur.push_back(cfg_stop2 ? 2 : 1); q_tag.push_back("R8"); end
    else if (cfg_frac_en) begin q_dur.push_back(16 + cfg_stop_frac); q_tag.push_back("R7"); end
    else begin q_dur.push_back(cfg_stop2 ? 32 : 16); q_tag.push_back("R6"); end
  endtask

  task automatic randcfg(bit iso);
    cfg_iso = iso; cfg_len = 2'($urandom); cfg_par_en = 1'($urandom);
    cfg_par_mode = 2'($urandom); cfg_stop2 = 1'($urandom);
    cfg_frac_en = 1'($urandom); cfg_stop_frac = 4'($urandom);
    cfg_multidrop = ($urandom % 4) == 0;
  endtask

  task automatic run(int cycles, int tick_pct, int valid_pct, int cfg_chg_pct);
    bit acc;
    string tg;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      acc = in_valid && m_ready();
      if (acc) build();
      else if (q_lv.size() > 0 && tick) begin
        q_dur[0]--;
        if (q_dur[0] == 0) begin
          void'(q_lv.pop_front()); void'(q_dur.pop_front()); void'(q_tag.pop_front());
        end
      end
      @(negedge clk);
      tg = (q_lv.size() > 0) ? q_tag[0] : "R1";
      chk(txd == ((q_lv.size() > 0) ? q_lv[0][0] : 1'b1), {tg, " R10 txd"}, txd,
          (q_lv.size() > 0) ? q_lv[0] : 1);
      chk(busy == (q_lv.size() > 0), "R1 busy", busy, q_lv.size() > 0);
      if (acc) in_valid = 0;
      if (!in_valid && ($urandom % 100) < valid_pct) begin
        in_valid = 1; in_data = 8'($urandom); in_addr = 1'($urandom);
      end
      tick = ($urandom % 100) < tick_pct;
      if (($urandom % 100) < cfg_chg_pct) randcfg(cfg_iso);
      #1;
      chk(in_ready == m_ready(), "R9 ready", in_ready, m_ready());
    end
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(txd == 1, "R1 reset txd", txd, 1);
    chk(busy == 0, "R1 reset busy", busy, 0);
    rst_n = 1;
    #1;
    chk(in_ready == 1, "R1 reset ready", in_ready, 1);

    ctx = "8E1 back-to-back R2 R4 R9";
    cfg_par_en = 1; cfg_par_mode = 0;
    run(1200, 100, 100, 0);
    ctx = "odd and forced parity R4";
    cfg_par_mode = 1; run(800, 70, 100, 0);
    cfg_par_mode = 2; run(800, 70, 100, 0);
    cfg_par_mode = 3; run(800, 70, 100, 0);
    ctx = "5-bit two stop R3 R6";
    cfg_len = 0; cfg_par_en = 0; cfg_stop2 = 1; run(1500, 60, 30, 0);
    ctx = "multidrop R5";
    cfg_multidrop = 1; cfg_par_en = 1; cfg_len = 3; run(1500, 80, 100, 0);
    cfg_multidrop = 0;
    ctx = "fractional stop R7";
    cfg_frac_en = 1;
    for (int f = 0; f < 16; f += 5) begin
      cfg_stop_frac = 4'(f); run(900, 90, 100, 0);
    end
    cfg_stop_frac = 15; run(900, 90, 100, 0);
    ctx = "isochronous R8";
    cfg_iso = 1; cfg_stop2 = 0; run(400, 50, 100, 0);
    cfg_stop2 = 1; run(400, 50, 100, 0);
    ctx = "random async";
    for (int b = 0; b < 12; b++) begin
      randcfg(0); run(2500, 20 + 10 * (b % 8), 10 + 15 * (b % 7), 0);
    end
    ctx = "random iso";
    for (int b = 0; b < 8; b++) begin
      randcfg(1); run(600, 30 + 10 * b, 20 + 10 * b, 0);
    end
    ctx = "mid-frame cfg change R11";
    randcfg(0); run(8000, 60, 50, 5);
    randcfg(1); run(2000, 50, 50, 10);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule